// File: doc/BRIEF.md
# Filtered Latching Fault Monitor

This block sits between the fault comparators of a multi-channel half-bridge driver and its register-access logic. Every raw fault input passes through its own time filter: a saturating counter that restarts whenever the input drops. When a filter reaches its length, the matching status bit is latched. Per-bridge overcurrent and open-load faults each have their own bit. Device-level faults each have one bit: temperature warning, thermal shutdown, main-supply undervoltage and overvoltage, undervoltage on each of the two bridge supply banks, and boost-rail undervoltage and overvoltage.

The latched bits drive the disable controls for the bridges and the boost converter. Each fault class has its own policy. Some faults are informational only. One turns off a single bridge, others turn off every bridge, and others stop the converter. A latched bit stays set until the register-access logic clears it, either bit by bit or all at once. The one exception is boost-rail overvoltage: with the recovery option on, that bit clears itself once its input drops. Filter lengths are parameters in clock cycles. Overcurrent, temperature and voltage filters default to 32 µs at 200 MHz, and open-load to 2 ms.

Top module: `fault_monitor`

## Requirements
- R1: After reset, `oc_stat_o`, `ol_stat_o`, `dev_stat_o`, `br_off_o` and `bst_off_o` are all zero.
- R2: A status bit is set at the clock edge on which its filter input has been sampled high for the filter length in consecutive cycles. One low sample restarts the count.
- R3: A filtered overcurrent on bridge i sets `oc_stat_o[i]` and forces `br_off_o[i]` high. No other bridge is affected. The bit holds until `clr_oc_i[i]` or `clr_all_i` is high at a clock edge.
- R4: Open-load on bridge i is filtered only while `br_on_i[i]` is high; a low `br_on_i[i]` restarts that filter. A set `ol_stat_o[i]` forces no bridge or converter off.
- R5: Temperature warning (`dev_stat_o[0]`) is latched for information only and forces no output off.
- R6: Thermal shutdown (`dev_stat_o[1]`) forces every bridge off. Clearing it has no effect while `tsd_raw_i` stays high.
- R7: Main-supply undervoltage (`dev_stat_o[2]`) forces every bridge and the converter off until the bit is cleared.
- R8: Main-supply overvoltage (`dev_stat_o[3]`) forces every bridge off unless `main_ov_keep_on_i` is high. It never stops the converter.
- R9: Undervoltage on bank 0 or bank 1 (`dev_stat_o[4]`, `dev_stat_o[5]`) forces every bridge off.
- R10: Boost-rail overvoltage (`dev_stat_o[7]`) forces the converter off. With `bst_autorec_i` high, the bit clears at the first edge where `bst_ov_raw_i` is low.
- R11: Boost-rail undervoltage (`dev_stat_o[6]`) is filtered only while the converter is active, meaning `bst_en_i` is high and `bst_off_o` is low. Once latched, it forces the converter off until cleared.
- R12: When a filtered fault event and a clear reach the same bit on the same edge, the bit stays set. `clr_all_i` clears every bit whose filter is not firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oc_raw_i | input | N_BR | Raw overcurrent per bridge |
| ol_raw_i | input | N_BR | Raw open-load per bridge |
| br_on_i | input | N_BR | Bridge commanded active |
| tw_raw_i | input | 1 | Raw temperature warning |
| tsd_raw_i | input | 1 | Raw over-temperature |
| main_uv_raw_i | input | 1 | Raw main-supply undervoltage |
| main_ov_raw_i | input | 1 | Raw main-supply overvoltage |
| bank_uv_raw_i | input | 2 | Raw undervoltage per bridge supply bank |
| bst_uv_raw_i | input | 1 | Raw boost-rail undervoltage |
| bst_ov_raw_i | input | 1 | Raw boost-rail overvoltage |
| bst_en_i | input | 1 | Converter enabled by configuration |
| main_ov_keep_on_i | input | 1 | Main overvoltage does not disable bridges |
| bst_autorec_i | input | 1 | Boost overvoltage self-recovery enable |
| clr_oc_i | input | N_BR | Clear overcurrent bits |
| clr_ol_i | input | N_BR | Clear open-load bits |
| clr_dev_i | input | 8 | Clear device status bits |
| clr_all_i | input | 1 | Clear every status bit |
| oc_stat_o | output | N_BR | Latched overcurrent |
| ol_stat_o | output | N_BR | Latched open-load |
| dev_stat_o | output | 8 | Latched device faults (bit map in R5 to R11) |
| br_off_o | output | N_BR | Bridge forced off |
| bst_off_o | output | 1 | Converter forced off |

## Verification
The assertions take for granted that every raw input, clear and configuration input is synchronous to `clk_i` and free of X once reset is released. They also take the clears to be level signals sampled at each edge, with no handshake. The stimulus drives every input only at the falling edge and keeps each value for whole cycles. It holds clears for single cycles and also for cycles in which a filter is firing, so that the set-over-clear ordering is exercised.

// File: rtl/fault_mon_pkg.sv
package fault_mon_pkg;
  localparam int DEV_W = 8;

  // bit order is the status word layout seen by register access
  typedef struct packed {
    logic       bst_ov;
    logic       bst_uv;
    logic [1:0] bank_uv;
    logic       main_ov;
    logic       main_uv;
    logic       tsd;
    logic       tw;
  } dev_stat_t;
endpackage

// File: rtl/fault_filter.sv
module fault_filter #(
  parameter int LEN = 6400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic hit_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!raw_i)               cnt_q <= '0;
    else if (cnt_q != CW'(LEN))    cnt_q <= cnt_q + 1'b1;
  end

  // fires on the sample that completes LEN consecutive highs
  assign hit_o = raw_i && (cnt_q >= CW'(LEN - 1));
endmodule

// File: rtl/fault_flag.sv
module fault_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/fault_monitor.sv
module fault_monitor
  import fault_mon_pkg::*;
#(
  parameter int N_BR     = 8,
  parameter int OC_LEN   = 6400,
  parameter int OL_LEN   = 400000,
  parameter int TEMP_LEN = 6400,
  parameter int VOLT_LEN = 6400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_BR-1:0]  oc_raw_i,
  input  logic [N_BR-1:0]  ol_raw_i,
  input  logic [N_BR-1:0]  br_on_i,
  input  logic             tw_raw_i,
  input  logic             tsd_raw_i,
  input  logic             main_uv_raw_i,
  input  logic             main_ov_raw_i,
  input  logic [1:0]       bank_uv_raw_i,
  input  logic             bst_uv_raw_i,
  input  logic             bst_ov_raw_i,
  input  logic             bst_en_i,
  input  logic             main_ov_keep_on_i,
  input  logic             bst_autorec_i,
  input  logic [N_BR-1:0]  clr_oc_i,
  input  logic [N_BR-1:0]  clr_ol_i,
  input  logic [DEV_W-1:0] clr_dev_i,
  input  logic             clr_all_i,
  output logic [N_BR-1:0]  oc_stat_o,
  output logic [N_BR-1:0]  ol_stat_o,
  output logic [DEV_W-1:0] dev_stat_o,
  output logic [N_BR-1:0]  br_off_o,
  output logic             bst_off_o
);
  localparam int BST_OV_BIT = DEV_W - 1;

  dev_stat_t        dev_q;
  dev_stat_t        dev_raw;
  logic [DEV_W-1:0] dev_hit;
  logic [DEV_W-1:0] dev_clr;
  logic [N_BR-1:0]  oc_hit;
  logic [N_BR-1:0]  ol_hit;
  logic             bst_active;
  logic             all_br_off;

  for (genvar b = 0; b < N_BR; b++) begin : g_br
    fault_filter #(.LEN(OC_LEN)) u_oc_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(oc_raw_i[b]), .hit_o(oc_hit[b])
    );
    fault_filter #(.LEN(OL_LEN)) u_ol_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(ol_raw_i[b] & br_on_i[b]), .hit_o(ol_hit[b])
    );
    fault_flag u_oc_flag (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(oc_hit[b]),
      .clr_i(clr_oc_i[b] | clr_all_i), .q_o(oc_stat_o[b])
    );
    fault_flag u_ol_flag (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ol_hit[b]),
      .clr_i(clr_ol_i[b] | clr_all_i), .q_o(ol_stat_o[b])
    );
  end

  assign bst_active = bst_en_i & ~bst_off_o;

  always_comb begin
    dev_raw         = '0;
    dev_raw.tw      = tw_raw_i;
    dev_raw.tsd     = tsd_raw_i;
    dev_raw.main_uv = main_uv_raw_i;
    dev_raw.main_ov = main_ov_raw_i;
    dev_raw.bank_uv = bank_uv_raw_i;
    dev_raw.bst_uv  = bst_uv_raw_i & bst_active;
    dev_raw.bst_ov  = bst_ov_raw_i;
  end

  for (genvar d = 0; d < DEV_W; d++) begin : g_dev
    localparam int FLEN = (d < 2) ? TEMP_LEN : VOLT_LEN;
    if (d == BST_OV_BIT) begin : g_rec
      assign dev_clr[d] = clr_dev_i[d] | clr_all_i | (bst_autorec_i & ~bst_ov_raw_i);
    end else begin : g_plain
      assign dev_clr[d] = clr_dev_i[d] | clr_all_i;
    end
    fault_filter #(.LEN(FLEN)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(dev_raw[d]), .hit_o(dev_hit[d])
    );
    fault_flag u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(dev_hit[d]),
      .clr_i(dev_clr[d]), .q_o(dev_q[d])
    );
  end

  assign all_br_off = dev_q.tsd | dev_q.main_uv | (dev_q.main_ov & ~main_ov_keep_on_i)
                    | (|dev_q.bank_uv);
  assign br_off_o   = oc_stat_o | {N_BR{all_br_off}};
  assign bst_off_o  = dev_q.main_uv | dev_q.bst_uv | dev_q.bst_ov;
  assign dev_stat_o = dev_q;
endmodule

// File: rtl/fault_monitor_chk.sv
module fault_monitor_chk #(
  parameter int N_BR = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_BR-1:0] oc_raw_i,
  input logic [N_BR-1:0] ol_raw_i,
  input logic [N_BR-1:0] br_on_i,
  input logic            bst_ov_raw_i,
  input logic            bst_en_i,
  input logic            bst_autorec_i,
  input logic [N_BR-1:0] clr_oc_i,
  input logic            clr_all_i,
  input logic [N_BR-1:0] oc_stat_o,
  input logic [N_BR-1:0] ol_stat_o,
  input logic [7:0]      dev_stat_o,
  input logic [N_BR-1:0] br_off_o,
  input logic            bst_off_o
);
  for (genvar b = 0; b < N_BR; b++) begin : g_b
    assert_oc_forces_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oc_stat_o[b] |-> br_off_o[b]);
    assert_oc_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oc_stat_o[b] && !clr_oc_i[b] && !clr_all_i) |=> oc_stat_o[b]);
    assert_oc_needs_raw_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(oc_stat_o[b]) |-> $past(oc_raw_i[b]));
    assert_ol_needs_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ol_stat_o[b]) |-> $past(br_on_i[b] && ol_raw_i[b]));
  end

  assert_tsd_all_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_stat_o[1] |-> (&br_off_o));
  assert_uv_all_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_stat_o[2] |-> (bst_off_o && (&br_off_o)));
  assert_bank_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dev_stat_o[5:4]) |-> (&br_off_o));
  assert_bst_ov_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_stat_o[7] |-> bst_off_o);
  assert_bst_recover_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_stat_o[7] && bst_autorec_i && !bst_ov_raw_i) |=> !dev_stat_o[7]);
  assert_bst_uv_active_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_stat_o[6]) |-> $past(bst_en_i && !bst_off_o));
endmodule

bind fault_monitor fault_monitor_chk #(.N_BR(N_BR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oc_raw_i(oc_raw_i), .ol_raw_i(ol_raw_i),
  .br_on_i(br_on_i), .bst_ov_raw_i(bst_ov_raw_i), .bst_en_i(bst_en_i),
  .bst_autorec_i(bst_autorec_i), .clr_oc_i(clr_oc_i), .clr_all_i(clr_all_i),
  .oc_stat_o(oc_stat_o), .ol_stat_o(ol_stat_o), .dev_stat_o(dev_stat_o),
  .br_off_o(br_off_o), .bst_off_o(bst_off_o)
);

// File: tb/fault_monitor_test.sv
`timescale 1ns/1ps
module fault_monitor_test;
  localparam int NB   = 8;
  localparam int OC_L = 4;
  localparam int OL_L = 12;
  localparam int TM_L = 5;
  localparam int VL_L = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] oc_raw = '0, ol_raw = '0, br_on = '0, clr_oc = '0, clr_ol = '0;
  logic tw_raw = 0, tsd_raw = 0, muv_raw = 0, mov_raw = 0, buv_raw = 0, bov_raw = 0;
  logic [1:0] bank_raw = '0;
  logic bst_en = 0, keep_on = 0, autorec = 0, clr_all = 0;
  logic [7:0] clr_dev = '0;
  logic [NB-1:0] oc_stat, ol_stat, br_off;
  logic [7:0] dev_stat;
  logic bst_off;

  always #2.5 clk = ~clk;

  fault_monitor #(.N_BR(NB), .OC_LEN(OC_L), .OL_LEN(OL_L), .TEMP_LEN(TM_L), .VOLT_LEN(VL_L)) uut (
    .clk_i(clk), .rst_ni(rst_n), .oc_raw_i(oc_raw), .ol_raw_i(ol_raw), .br_on_i(br_on),
    .tw_raw_i(tw_raw), .tsd_raw_i(tsd_raw), .main_uv_raw_i(muv_raw), .main_ov_raw_i(mov_raw),
    .bank_uv_raw_i(bank_raw), .bst_uv_raw_i(buv_raw), .bst_ov_raw_i(bov_raw),
    .bst_en_i(bst_en), .main_ov_keep_on_i(keep_on), .bst_autorec_i(autorec),
    .clr_oc_i(clr_oc), .clr_ol_i(clr_ol), .clr_dev_i(clr_dev), .clr_all_i(clr_all),
    .oc_stat_o(oc_stat), .ol_stat_o(ol_stat), .dev_stat_o(dev_stat),
    .br_off_o(br_off), .bst_off_o(bst_off)
  );

  // reference model state
  int n_chk = 0, n_fail = 0;
  string req = "R1";
  bit done = 0;
  int c_oc[NB], c_ol[NB], c_dev[8];
  logic [NB-1:0] m_oc = '0, m_ol = '0;
  logic [7:0] m_dev = '0;

  task automatic filt(inout int c, input logic raw, input int len, output logic hit);
    if (raw) c = (c < len) ? c + 1 : len;
    else c = 0;
    hit = raw && (c >= len);
  endtask

  function automatic logic m_bst_off();
    return m_dev[2] | m_dev[6] | m_dev[7];
  endfunction

  task automatic model();
    logic h, act, clr;
    logic [7:0] raw;
    if (!rst_n) begin
      m_oc = '0; m_ol = '0; m_dev = '0;
      foreach (c_oc[i]) begin c_oc[i] = 0; c_ol[i] = 0; end
      foreach (c_dev[i]) c_dev[i] = 0;
      return;
    end
    act = bst_en && !m_bst_off();
    for (int i = 0; i < NB; i++) begin
      filt(c_oc[i], oc_raw[i], OC_L, h);
      if (h) m_oc[i] = 1; else if (clr_oc[i] || clr_all) m_oc[i] = 0;
      filt(c_ol[i], ol_raw[i] && br_on[i], OL_L, h);
      if (h) m_ol[i] = 1; else if (clr_ol[i] || clr_all) m_ol[i] = 0;
    end
    raw = {bov_raw, buv_raw && act, bank_raw, mov_raw, muv_raw, tsd_raw, tw_raw};
    for (int d = 0; d < 8; d++) begin
      filt(c_dev[d], raw[d], (d < 2) ? TM_L : VL_L, h);
      clr = clr_dev[d] || clr_all || (d == 7 && autorec && !bov_raw);
      if (h) m_dev[d] = 1; else if (clr) m_dev[d] = 0;
    end
  endtask

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic all;
    logic [NB-1:0] e_off;
    all = m_dev[1] | m_dev[2] | (m_dev[3] & !keep_on) | m_dev[4] | m_dev[5];
    for (int i = 0; i < NB; i++) e_off[i] = m_oc[i] | all;
    chk("oc_stat", 16'(oc_stat), 16'(m_oc));
    chk("ol_stat", 16'(ol_stat), 16'(m_ol));
    chk("dev_stat", 16'(dev_stat), 16'(m_dev));
    chk("br_off", 16'(br_off), 16'(e_off));
    chk("bst_off", 16'(bst_off), 16'(m_bst_off()));
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1; model();
      @(negedge clk); compare();
      clr_oc = '0; clr_ol = '0; clr_dev = '0; clr_all = 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    req = "R1"; step(3);
    @(negedge clk); rst_n = 1; step(2);

    // R2 filter restart then completion
    req = "R2"; oc_raw[0] = 1; step(3); oc_raw[0] = 0; step(1);
    oc_raw[0] = 1; step(OC_L + 1);

    // R3 only bridge 0 off; R12 clear while firing keeps bit
    req = "R12"; clr_oc[0] = 1; step(2);
    req = "R3"; oc_raw[0] = 0; step(3); clr_oc[5] = 1; step(2);
    clr_oc[0] = 1; step(2);

    // R4 open-load qualified by bridge activity, informational
    req = "R4"; ol_raw[2] = 1; step(OL_L + 4);
    br_on[2] = 1; step(OL_L - 2); br_on[2] = 0; step(1); br_on[2] = 1; step(OL_L + 2);
    ol_raw[2] = 0; br_on[2] = 0; clr_ol[2] = 1; step(2);

    // R5 temperature warning
    req = "R5"; tw_raw = 1; step(TM_L + 2); tw_raw = 0; clr_dev[0] = 1; step(2);

    // R6 thermal shutdown, clear ineffective while hot
    req = "R6"; tsd_raw = 1; step(TM_L + 2); clr_dev[1] = 1; step(3);
    tsd_raw = 0; step(2); clr_dev[1] = 1; step(2);

    // R7 main undervoltage
    req = "R7"; muv_raw = 1; step(VL_L + 1); muv_raw = 0; step(3); clr_dev[2] = 1; step(2);

    // R8 main overvoltage with and without keep-on
    req = "R8"; bst_en = 1; mov_raw = 1; step(VL_L + 1); mov_raw = 0; step(2);
    keep_on = 1; step(3); keep_on = 0; step(1); clr_dev[3] = 1; step(2);

    // R9 bank undervoltage
    req = "R9"; bank_raw = 2'b10; step(VL_L + 1); bank_raw = 0; clr_dev[5] = 1; step(2);
    bank_raw = 2'b01; step(VL_L + 1); bank_raw = 0; clr_dev[4] = 1; step(2);

    // R10 boost overvoltage: latched, then self-recovering
    req = "R10"; bov_raw = 1; step(VL_L + 1); bov_raw = 0; step(3); clr_dev[7] = 1; step(2);
    autorec = 1; bov_raw = 1; step(VL_L + 2); bov_raw = 0; step(3); autorec = 0;

    // R11 boost undervoltage only while converter active
    req = "R11"; bst_en = 0; buv_raw = 1; step(VL_L + 3);
    bst_en = 1; step(VL_L + 3); buv_raw = 0; step(2); clr_dev[6] = 1; step(2);

    // R12 clear-all with one filter still firing
    req = "R12"; oc_raw[3] = 1; oc_raw[6] = 1; tw_raw = 1; step(OC_L + 2);
    oc_raw[6] = 0; clr_all = 1; step(2);
    oc_raw = '0; tw_raw = 0; clr_all = 1; step(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule